// File: doc/BRIEF.md
# RC4 40-bit Key Search Engine

This block tries every 40-bit RC4 key in a given range against one known plaintext/ciphertext pair. For each candidate key a scheduling unit builds the 256-byte permutation state, one swap per clock. A trial unit then takes that finished state, produces keystream, XORs it with the known plaintext and compares the result with the known ciphertext over a chosen number of bytes. It stops at the first byte that differs.

Two state banks alternate between the two units. While the trial unit tests candidate k, the scheduler is already building the state for candidate k+1. Each bank is reloaded with the identity permutation in a single cycle when its trial ends. The steady-state rate is therefore one candidate per 256 cycles.

A search begins with a one-cycle `start` pulse. It ends with `done`, together with `found` and the matching key, or with `done` and `found` low when no key in the range matches.

Top module: `rc4_key_search`

## Requirements
- R1: After reset, `busy`, `found` and `done` are low and `match_key` is zero.
- R2: Key byte m (m = 0..4) is `key[39-8m -: 8]`, so the most significant byte comes first. The state starts as S[x]=x. For i = 0..255 the scheduler sets j = j + S[i] + keybyte[i mod 5] (mod 256) and swaps S[i] and S[j].
- R3: Keystream byte b is produced by i=i+1, j=j+S[i], swap S[i] and S[j], then taking S[S[i]+S[j]]. Bytes are numbered from b=0, and byte b of the plaintext and ciphertext ports sits at bits [8b+7:8b]. A candidate matches when plaintext byte XOR keystream byte equals ciphertext byte for every b below `cmp_len`.
- R4: Candidates are tried in ascending order from `first_key` through `last_key`, both inclusive. The reported key is the lowest one in the range that matches, and this includes the last key of the range.
- R5: On a match, `done` and `found` go high, `busy` goes low, and `match_key` holds the key. All three hold until the next accepted `start`.
- R6: If no key in the range matches, `done` goes high, `busy` goes low and `found` stays low.
- R7: Without a match, a range of N keys raises `done` no earlier than 256·N and no later than 256·N + 2·`cmp_len` + 2 cycles after the `start` edge.
- R8: A `start` pulse that arrives while `busy` is high has no effect on the search under way or on its result.
- R9: Ciphertext and plaintext bytes at or above index `cmp_len` have no effect on the result.
- R10: An accepted `start` raises `busy` from the next cycle until `done`.
- R11: An accepted `start` clears `found` and `done` in the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search, taken only when idle |
| first_key | input | 40 | Lowest candidate key |
| last_key | input | 40 | Highest candidate key |
| known_pt | input | 64 | Known plaintext, byte 0 in bits [7:0] |
| known_ct | input | 64 | Known ciphertext, byte 0 in bits [7:0] |
| cmp_len | input | 4 | Number of bytes compared, 1 to 8 |
| busy | output | 1 | Search in progress |
| found | output | 1 | A matching key was found |
| match_key | output | 40 | Key that matched |
| done | output | 1 | Search finished |

## Verification
The assertions assume three things about the inputs at an accepted `start`. The range must be ordered, with `first_key` not above `last_key`. `cmp_len` must lie between 1 and 8. The range, text and length ports must stay unchanged for the whole search. Every search in the bench is issued with an ordered range and a length in that interval, and those inputs are held steady until `done`. The single stray `start` issued mid-search changes only the range ports, and it arrives while the engine is busy, which is exactly the case the design must ignore. The expected key for each run comes from a keystream model inside the bench, swept over every key in the small range.

// File: rtl/rc4s_pkg.sv
package rc4s_pkg;
  localparam int SBYTE_W = 8;
  typedef enum logic [1:0] {KS_IDLE, KS_RUN, KS_HOLD} ks_state_e;
endpackage

// File: rtl/rc4_state_bank.sv
module rc4_state_bank #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          init,
  input  logic          we,
  input  logic [AW-1:0] wa0,
  input  logic [AW-1:0] wd0,
  input  logic [AW-1:0] wa1,
  input  logic [AW-1:0] wd1,
  input  logic [AW-1:0] ra0,
  input  logic [AW-1:0] ra1,
  output logic [AW-1:0] rd0,
  output logic [AW-1:0] rd1
);
  localparam int DEPTH = 1 << AW;
  logic [AW-1:0] mem [DEPTH];

  // identity reload in one cycle, otherwise a two-entry swap write
  always_ff @(posedge clk) begin
    if (init) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= AW'(k);
    end else if (we) begin
      mem[wa0] <= wd0;
      mem[wa1] <= wd1;
    end
  end

  assign rd0 = mem[ra0];
  assign rd1 = mem[ra1];
endmodule

// File: rtl/rc4_ksa_unit.sv
module rc4_ksa_unit #(
  parameter int KEY_BYTES = 5,
  parameter int AW        = 8,
  localparam int KEY_W    = 8 * KEY_BYTES,
  localparam int KIDX_W   = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step_en,
  input  logic [KEY_W-1:0] key,
  input  logic [AW-1:0]    rd0,
  input  logic [AW-1:0]    rd1,
  output logic [AW-1:0]    ra0,
  output logic [AW-1:0]    ra1,
  output logic             we,
  output logic [AW-1:0]    wa0,
  output logic [AW-1:0]    wd0,
  output logic [AW-1:0]    wa1,
  output logic [AW-1:0]    wd1,
  output logic             at_last
);
  logic [AW-1:0]     i_q, j_q, j_n;
  logic [KIDX_W-1:0] k_q;
  logic [7:0]        kbyte;

  always_comb begin
    kbyte = '0;
    for (int m = 0; m < KEY_BYTES; m++)
      if (k_q == KIDX_W'(m)) kbyte = key[8*(KEY_BYTES-1-m) +: 8];
  end

  assign ra0     = i_q;
  assign j_n     = j_q + rd0 + AW'(kbyte);
  assign ra1     = j_n;
  assign we      = step_en;
  assign wa0     = i_q;
  assign wd0     = rd1;
  assign wa1     = j_n;
  assign wd1     = rd0;
  assign at_last = (i_q == '1);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      i_q <= '0;
      j_q <= '0;
      k_q <= '0;
    end else if (step_en) begin
      i_q <= i_q + 1'b1;
      j_q <= j_n;
      k_q <= (k_q == KIDX_W'(KEY_BYTES-1)) ? '0 : k_q + 1'b1;
    end
  end

  // R2
  kidx_range_chk: assert property (@(posedge clk) disable iff (rst)
    k_q < KIDX_W'(KEY_BYTES));
  // R2
  ksa_first_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_en && i_q == '0) |-> (j_q == '0 && k_q == '0));
endmodule

// File: rtl/rc4_trial_unit.sv
module rc4_trial_unit #(
  parameter int CMP_MAX = 8,
  parameter int AW      = 8,
  localparam int LEN_W  = $clog2(CMP_MAX + 1),
  localparam int TXT_W  = 8 * CMP_MAX,
  localparam int CYC_W  = $clog2(2 * CMP_MAX + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [TXT_W-1:0] pt,
  input  logic [TXT_W-1:0] ct,
  input  logic [LEN_W-1:0] cmp_len,
  input  logic [AW-1:0]    rd0,
  input  logic [AW-1:0]    rd1,
  output logic [AW-1:0]    ra0,
  output logic [AW-1:0]    ra1,
  output logic             we,
  output logic [AW-1:0]    wa0,
  output logic [AW-1:0]    wd0,
  output logic [AW-1:0]    wa1,
  output logic [AW-1:0]    wd1,
  output logic             busy,
  output logic             fin,
  output logic             hit
);
  logic             busy_q, out_q, ok;
  logic [AW-1:0]    i_q, j_q, t_q, i_n, j_n;
  logic [LEN_W-1:0] b_q;
  logic [CYC_W-1:0] cyc_q;
  logic [7:0]       pb, cb;

  always_comb begin
    pb = '0;
    cb = '0;
    for (int m = 0; m < CMP_MAX; m++)
      if (b_q == LEN_W'(m)) begin
        pb = pt[8*m +: 8];
        cb = ct[8*m +: 8];
      end
  end

  // swap phase reads S[i+1] then S[j'], output phase reads S[t]
  assign i_n  = i_q + 1'b1;
  assign ra0  = out_q ? t_q : i_n;
  assign j_n  = j_q + rd0;
  assign ra1  = out_q ? j_q : j_n;
  assign we   = busy_q && !out_q;
  assign wa0  = i_n;
  assign wd0  = rd1;
  assign wa1  = j_n;
  assign wd1  = rd0;
  assign ok   = ((pb ^ 8'(rd0)) == cb);
  assign fin  = busy_q && out_q && (!ok || b_q == cmp_len - 1'b1);
  assign hit  = fin && ok;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      out_q  <= 1'b0;
      i_q    <= '0;
      j_q    <= '0;
      t_q    <= '0;
      b_q    <= '0;
      cyc_q  <= '0;
    end else if (go) begin
      busy_q <= 1'b1;
      out_q  <= 1'b0;
      i_q    <= '0;
      j_q    <= '0;
      b_q    <= '0;
      cyc_q  <= '0;
    end else if (busy_q) begin
      cyc_q <= cyc_q + 1'b1;
      if (!out_q) begin
        i_q   <= i_n;
        j_q   <= j_n;
        t_q   <= rd0 + rd1;
        out_q <= 1'b1;
      end else begin
        out_q <= 1'b0;
        if (fin) busy_q <= 1'b0;
        else     b_q    <= b_q + 1'b1;
      end
    end
  end

  // R3
  byte_idx_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> b_q < cmp_len);
  // R7
  trial_len_chk: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> cyc_q < CYC_W'(2 * CMP_MAX));
endmodule

// File: rtl/rc4_key_search.sv
module rc4_key_search
  import rc4s_pkg::*;
#(
  parameter int KEY_BYTES = 5,
  parameter int CMP_MAX   = 8,
  localparam int KEY_W    = 8 * KEY_BYTES,
  localparam int TXT_W    = 8 * CMP_MAX,
  localparam int LEN_W    = $clog2(CMP_MAX + 1),
  localparam int AW       = SBYTE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [KEY_W-1:0] first_key,
  input  logic [KEY_W-1:0] last_key,
  input  logic [TXT_W-1:0] known_pt,
  input  logic [TXT_W-1:0] known_ct,
  input  logic [LEN_W-1:0] cmp_len,
  output logic             busy,
  output logic             found,
  output logic [KEY_W-1:0] match_key,
  output logic             done
);
  ks_state_e        ks_q;
  logic [KEY_W-1:0] ks_key_q, tr_key_q, last_q;
  logic [TXT_W-1:0] pt_q, ct_q;
  logic [LEN_W-1:0] len_q;
  logic             ksa_bank_q, go_start, handoff, k_step, k_restart, k_at_last;
  logic [8:0]       gap_q;

  logic [AW-1:0] k_ra0, k_ra1, k_wa0, k_wd0, k_wa1, k_wd1, k_rd0, k_rd1;
  logic [AW-1:0] t_ra0, t_ra1, t_wa0, t_wd0, t_wa1, t_wd1, t_rd0, t_rd1;
  logic          k_we, t_we, t_busy, t_fin, t_hit;

  logic [AW-1:0] b_ra0 [2];
  logic [AW-1:0] b_ra1 [2];
  logic [AW-1:0] b_wa0 [2];
  logic [AW-1:0] b_wd0 [2];
  logic [AW-1:0] b_wa1 [2];
  logic [AW-1:0] b_wd1 [2];
  logic [AW-1:0] b_rd0 [2];
  logic [AW-1:0] b_rd1 [2];
  logic          b_we  [2];
  logic          b_init[2];

  assign go_start  = start && !busy;
  assign handoff   = ((ks_q == KS_RUN && k_at_last) || ks_q == KS_HOLD) && !t_busy;
  assign k_step    = (ks_q == KS_RUN);
  assign k_restart = go_start || handoff;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic own_k;
    assign own_k     = (ksa_bank_q == 1'(g));
    assign b_ra0[g]  = own_k ? k_ra0 : t_ra0;
    assign b_ra1[g]  = own_k ? k_ra1 : t_ra1;
    assign b_wa0[g]  = own_k ? k_wa0 : t_wa0;
    assign b_wd0[g]  = own_k ? k_wd0 : t_wd0;
    assign b_wa1[g]  = own_k ? k_wa1 : t_wa1;
    assign b_wd1[g]  = own_k ? k_wd1 : t_wd1;
    assign b_we[g]   = own_k ? k_we  : t_we;
    assign b_init[g] = rst || go_start || (!own_k && t_fin);

    rc4_state_bank #(.AW(AW)) u_bank (
      .clk (clk), .init(b_init[g]), .we(b_we[g]),
      .wa0 (b_wa0[g]), .wd0(b_wd0[g]), .wa1(b_wa1[g]), .wd1(b_wd1[g]),
      .ra0 (b_ra0[g]), .ra1(b_ra1[g]), .rd0(b_rd0[g]), .rd1(b_rd1[g]));
  end

  assign k_rd0 = b_rd0[ksa_bank_q];
  assign k_rd1 = b_rd1[ksa_bank_q];
  assign t_rd0 = b_rd0[~ksa_bank_q];
  assign t_rd1 = b_rd1[~ksa_bank_q];

  rc4_ksa_unit #(.KEY_BYTES(KEY_BYTES), .AW(AW)) u_ksa (
    .clk(clk), .rst(rst), .restart(k_restart), .step_en(k_step), .key(ks_key_q),
    .rd0(k_rd0), .rd1(k_rd1), .ra0(k_ra0), .ra1(k_ra1), .we(k_we),
    .wa0(k_wa0), .wd0(k_wd0), .wa1(k_wa1), .wd1(k_wd1), .at_last(k_at_last));

  rc4_trial_unit #(.CMP_MAX(CMP_MAX), .AW(AW)) u_trial (
    .clk(clk), .rst(rst), .go(handoff), .pt(pt_q), .ct(ct_q), .cmp_len(len_q),
    .rd0(t_rd0), .rd1(t_rd1), .ra0(t_ra0), .ra1(t_ra1), .we(t_we),
    .wa0(t_wa0), .wd0(t_wd0), .wa1(t_wa1), .wd1(t_wd1),
    .busy(t_busy), .fin(t_fin), .hit(t_hit));

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_q       <= KS_IDLE;
      ks_key_q   <= '0;
      tr_key_q   <= '0;
      last_q     <= '0;
      pt_q       <= '0;
      ct_q       <= '0;
      len_q      <= '0;
      ksa_bank_q <= 1'b0;
      busy       <= 1'b0;
      found      <= 1'b0;
      done       <= 1'b0;
      match_key  <= '0;
    end else if (go_start) begin
      ks_q     <= KS_RUN;
      ks_key_q <= first_key;
      last_q   <= last_key;
      pt_q     <= known_pt;
      ct_q     <= known_ct;
      len_q    <= cmp_len;
      busy     <= 1'b1;
      found    <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (ks_q == KS_RUN && k_at_last && t_busy) ks_q <= KS_HOLD;
      if (handoff) begin
        ksa_bank_q <= ~ksa_bank_q;
        tr_key_q   <= ks_key_q;
        if (ks_key_q == last_q) begin
          ks_q <= KS_IDLE;
        end else begin
          ks_q     <= KS_RUN;
          ks_key_q <= ks_key_q + 1'b1;
        end
      end
      if (t_hit) begin
        found     <= 1'b1;
        done      <= 1'b1;
        busy      <= 1'b0;
        match_key <= tr_key_q;
        ks_q      <= KS_IDLE;
      end else if (busy && ks_q == KS_IDLE && !t_busy) begin
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || go_start || handoff) gap_q <= '0;
    else if (gap_q != '1)           gap_q <= gap_q + 1'b1;
  end

  // R7
  handoff_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    handoff |-> gap_q >= 9'd255);
  // R5
  found_done_chk: assert property (@(posedge clk) disable iff (rst)
    found |-> done);
  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> (done && $stable(found) && $stable(match_key)));
  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R4
  start_args_chk: assert property (@(posedge clk) disable iff (rst)
    go_start |-> (first_key <= last_key && cmp_len >= LEN_W'(1) && cmp_len <= LEN_W'(CMP_MAX)));
endmodule

// File: tb/tb_rc4_key_search.sv
module tb_rc4_key_search;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [39:0] first_key = '0, last_key = '0;
  logic [63:0] known_pt = '0, known_ct = '0;
  logic [3:0]  cmp_len = 4'd8;
  logic        busy, found, done;
  logic [39:0] match_key;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rc4_key_search dut (
    .clk(clk), .rst(rst), .start(start), .first_key(first_key), .last_key(last_key),
    .known_pt(known_pt), .known_ct(known_ct), .cmp_len(cmp_len),
    .busy(busy), .found(found), .match_key(match_key), .done(done));

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_ks(input logic [39:0] k);
    logic [7:0]  s [256];
    logic [7:0]  i, j, t, tmp;
    logic [63:0] r;
    for (int n = 0; n < 256; n++) s[n] = 8'(n);
    j = 8'd0;
    for (int n = 0; n < 256; n++) begin
      j = j + s[n] + k[8*(4-(n%5)) +: 8];
      tmp = s[n]; s[n] = s[j]; s[j] = tmp;
    end
    i = 8'd0; j = 8'd0; r = '0;
    for (int b = 0; b < 8; b++) begin
      i = i + 8'd1;
      j = j + s[i];
      tmp = s[i]; s[i] = s[j]; s[j] = tmp;
      t = s[i] + s[j];
      r[8*b +: 8] = s[t];
    end
    return r;
  endfunction

  task automatic run_search(input logic [39:0] f, input logic [39:0] l, input logic [63:0] p,
                            input logic [63:0] c, input int len, input bit poke, input string tag);
    logic [63:0] mask;
    bit          exp_found = 0;
    logic [39:0] exp_key = '0;
    longint      n_keys = longint'(l - f) + 1;
    int          cnt;
    mask = (len >= 8) ? '1 : ((64'd1 << (8*len)) - 64'd1);
    for (longint o = 0; o < n_keys; o++) begin
      if (!exp_found && (((p ^ ref_ks(f + 40'(o))) & mask) == (c & mask))) begin
        exp_found = 1;
        exp_key   = f + 40'(o);
      end
    end
    @(negedge clk);
    first_key = f; last_key = l; known_pt = p; known_ct = c; cmp_len = 4'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R10, R11: busy up, old result cleared one edge after start
    chk(busy == 1'b1, {"R10 busy after start ", tag}, 64'(busy), 64'd1);
    chk(!found && !done, {"R11 result cleared ", tag}, {found, done}, 64'd0);
    cnt = 1;
    while (!done && cnt < 20000) begin
      if (poke && cnt == 300) begin
        first_key = l + 40'd1; last_key = l + 40'd1;
        start = 1'b1;
      end else if (poke && cnt == 301) begin
        start = 1'b0;
        first_key = f; last_key = l;
      end
      @(negedge clk);
      cnt++;
    end
    chk(done == 1'b1, {"R6 done raised ", tag}, 64'(done), 64'd1);
    chk(found == exp_found, {"R4 found flag ", tag}, 64'(found), 64'(exp_found));
    chk(busy == 1'b0, {"R5 busy low at end ", tag}, 64'(busy), 64'd0);
    if (exp_found) begin
      chk(match_key == exp_key, {"R5 matching key ", tag}, 64'(match_key), 64'(exp_key));
      chk(cnt <= 256*(int'(exp_key - f) + 1) + 2*len + 2, {"R4 stop at first hit ", tag},
          64'(cnt), 64'(256*(int'(exp_key - f) + 1) + 2*len + 2));
    end else begin
      chk(cnt >= 256*int'(n_keys) && cnt <= 256*int'(n_keys) + 2*len + 2,
          {"R7 search time ", tag}, 64'(cnt), 64'(256*int'(n_keys)));
    end
    repeat (3) @(negedge clk);
    // R5: result held while idle
    chk(done && found == exp_found, {"R5 result held ", tag}, {found, done}, {exp_found, 1'b1});
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [39:0] base;
    logic [63:0] pt, ct, ct3;
    base = 40'h1F2E3D4C00;
    pt   = 64'h0123456789ABCDEF;
    ct   = pt ^ ref_ks(base + 40'd5);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !found && !done, "R1 flags after reset", {busy, found, done}, 64'd0);
    chk(match_key == '0, "R1 key after reset", 64'(match_key), 64'd0);

    // R2 R3 R4 R5: target inside the range
    run_search(base, base + 40'd9, pt, ct, 8, 1'b0, "inner");
    // R6 R7: range above the target
    run_search(base + 40'd6, base + 40'd13, pt, ct, 8, 1'b0, "miss");
    // R4: target is the final candidate, flushed through the trial stage
    run_search(base, base + 40'd5, pt, ct, 8, 1'b0, "last");
    // single-key ranges
    run_search(base + 40'd5, base + 40'd5, pt, ct, 8, 1'b0, "one_hit");
    run_search(base + 40'd4, base + 40'd4, pt, ct, 8, 1'b0, "one_miss");
    // R9: bytes at or above cmp_len carry garbage
    ct3 = (ct & 64'h0000_0000_00FF_FFFF) | (~ct & 64'hFFFF_FFFF_FF00_0000);
    run_search(base, base + 40'd7, pt, ct3, 3, 1'b0, "r9_len3");
    // R3: one- and two-byte compares over 16 keys, expected first hit from the model
    run_search(base + 40'h40, base + 40'h4F, pt,
               {56'd0, pt[7:0] ^ ref_ks(base + 40'h47)[7:0]}, 1, 1'b0, "len1");
    run_search(base + 40'h40, base + 40'h4F, pt,
               {48'd0, pt[15:0] ^ ref_ks(base + 40'h4B)[15:0]}, 2, 1'b0, "len2");
    // R8: stray start while busy
    run_search(base, base + 40'd9, pt, ct, 8, 1'b1, "r8_poke");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule